// File: doc/BRIEF.md
# SPI master with FIFO register interface

This block is a memory-mapped serial port that acts as the master on an SPI link. Software writes words into an eight-entry transmit queue through a data register. While the port is enabled, a sequencer moves each word through a shift engine and places the word that comes back into an eight-entry receive queue, where software reads it through the same data register. The frame width runs from 1 to 16 bits. It is set by a 4-bit size field that holds the width minus one. Every word is trimmed to that width on the way into the transmit queue and again on the way into the receive queue.

A loopback setting sends each outgoing word straight back into the receive queue, and the serial pins stay idle while it is active. Status flags report the fill state of both queues. Two level interrupt sources fire when the receive queue is at least half full and when the transmit queue is at most half full. A mask register combines them into a single interrupt line. A read-only window at the top of the address space returns eight identification bytes. The serial link runs in mode 0: data out changes when the clock falls, data in is sampled when it rises, the most significant bit goes first, and an active-low select stays low for the whole frame.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, the status register (word offset 0x0C) reads 0x03, the raw interrupt register (0x18) reads 0x08, the mask register (0x14) and the masked interrupt register (0x1C) read 0, and `irq` is low.
- R2: The low 4 bits of the frame register (0x00) hold N, and the frame width is N+1 bits. A word written to the data register (0x08) and the word stored into the receive queue are both ANDed with a mask of N+1 ones.
- R3: A data-register write while the transmit queue already holds 8 words is dropped. Only the first 8 words are later transferred, in the order they were written.
- R4: A data-register read while the receive queue is empty returns 0 and leaves the status unchanged.
- R5: While the enable bit (bit 1 of the control register at 0x04) is 0, nothing leaves the transmit queue.
- R6: A transfer starts only while the receive queue holds fewer than 8 words, so a full receive queue stalls transmission. Each read that frees a slot lets exactly one more word through, and order is kept.
- R7: With the loopback bit (bit 0 of the control register) set, each transmitted word appears unchanged in the receive queue, `spi_ncs` stays high and `spi_sclk` stays low.
- R8: Outside loopback, a frame of N+1 bits holds `spi_ncs` low, gives N+1 rising edges of `spi_sclk`, and sends the word MSB first on `spi_mosi`. The word pushed into the receive queue is the `spi_miso` values sampled on those rising edges, MSB first.
- R9: The status bits are: bit0 transmit queue empty, bit1 transmit queue not full, bit2 receive queue not empty, bit3 receive queue full, bit4 busy. Busy is 1 whenever the transmit queue holds any word.
- R10: Raw interrupt bit 2 is 1 when the receive queue holds 4 or more words. Raw interrupt bit 3 is 1 when the transmit queue holds 4 or fewer words. The masked register equals raw AND mask, and `irq` is high exactly when that value is nonzero.
- R11: The prescale register (0x10) keeps only 8 bits. Each `spi_sclk` half period lasts max(prescale, 1) clock cycles.
- R12: Reads at offsets 0xFE0 to 0xFFC return the bytes 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, selected by (offset - 0xFE0)/4.
- R13: The DMA register (0x20) and all unmapped offsets read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a read of the data register pops the receive queue |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Combined masked interrupt |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ncs | output | 1 | Active-low select, low for the whole frame |

## Verification
The hardest state to reach is a receive queue that is full while the transmit queue still holds words. Only that state shows the stall and the one-word-per-free-slot release. The bench gets there in loopback mode: it fills the receive queue with eight transfers, writes two more words that must stay queued, and then frees slots one at a time. A second difficult case is a transmit queue that overflows. The bench builds it with the port disabled, so nothing drains while nine words are written. It then enables the port and checks that exactly eight come back.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int WORD_W     = 16;
    localparam int FIFO_DEPTH = 8;
    localparam int ADDR_W     = 12;
    localparam int SIZE_W     = 4;
    localparam int DIV_W      = 8;

    // Register word indices (byte offset / 4); software decodes these.
    localparam logic [9:0] RG_FRAME = 10'd0;
    localparam logic [9:0] RG_CTRL  = 10'd1;
    localparam logic [9:0] RG_DATA  = 10'd2;
    localparam logic [9:0] RG_STAT  = 10'd3;
    localparam logic [9:0] RG_DIV   = 10'd4;
    localparam logic [9:0] RG_IEN   = 10'd5;
    localparam logic [9:0] RG_IRAW  = 10'd6;
    localparam logic [9:0] RG_IACT  = 10'd7;
    localparam logic [9:0] RG_DMA   = 10'd8;

    // Control bit positions
    localparam int CB_LOOP   = 0;
    localparam int CB_ENABLE = 1;

    typedef struct packed {
        logic busy;
        logic rx_full;
        logic rx_nempty;
        logic tx_nfull;
        logic tx_empty;
    } stat_t;

    typedef struct packed {
        logic       tx_low;
        logic       rx_high;
        logic [1:0] unused;
    } irq_t;

    function automatic logic [WORD_W-1:0] frame_mask(input logic [SIZE_W-1:0] size);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W; i++) begin
            m[i] = (i <= int'(size));
        end
        return m;
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h22;
            3'd1:    return 8'h10;
            3'd2:    return 8'h04;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign dout  = mem[rptr];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
    parameter int W  = 16,
    parameter int SW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [W-1:0]  word,
    input  logic [SW-1:0] top_bit,
    input  logic [DW-1:0] div,
    input  logic          miso,
    output logic          sclk,
    output logic          mosi,
    output logic          ncs,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  rx_word
);

    logic [DW-1:0] half_q, cnt_q;
    logic [SW-1:0] idx_q;
    logic [W-1:0]  tx_q, rx_q;
    logic          busy_q, sclk_q;
    logic          edge_now;

    assign edge_now = busy_q && (cnt_q == half_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            cnt_q  <= '0;
            idx_q  <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            half_q <= DW'(1);
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                sclk_q <= 1'b0;
                cnt_q  <= '0;
                idx_q  <= top_bit;
                tx_q   <= word;
                rx_q   <= '0;
                half_q <= (div == '0) ? DW'(1) : div;
            end
        end else if (edge_now) begin
            cnt_q <= '0;
            if (!sclk_q) begin
                sclk_q <= 1'b1;
                rx_q   <= {rx_q[W-2:0], miso};
            end else begin
                sclk_q <= 1'b0;
                if (idx_q == '0) busy_q <= 1'b0;
                else             idx_q  <= idx_q - 1'b1;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = busy_q & tx_q[idx_q];
    assign ncs     = ~busy_q;
    assign busy    = busy_q;
    assign done    = edge_now && sclk_q && (idx_q == '0);
    assign rx_word = rx_q;

    assert_sclk_in_frame_R8: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !ncs);

    assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> !start);

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spim_pkg::*;
#(
    parameter int WW    = spim_pkg::WORD_W,
    parameter int DEPTH = spim_pkg::FIFO_DEPTH,
    parameter int AW    = spim_pkg::ADDR_W,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int HALF = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [15:0]   bus_wdata,
    output logic [15:0]   bus_rdata,
    output logic          irq,
    output logic          spi_sclk,
    output logic          spi_mosi,
    input  logic          spi_miso,
    output logic          spi_ncs
);

    logic [15:0]       frame_q;
    logic [3:0]        ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic [3:0]        ien_q;

    logic [9:0]        reg_sel;
    logic              id_win;
    logic [WW-1:0]     fmask;

    logic              tx_push, tx_pop, tx_full, tx_empty;
    logic [WW-1:0]     tx_din, tx_dout;
    logic [CW-1:0]     tx_count;
    logic              rx_push, rx_pop, rx_full, rx_empty;
    logic [WW-1:0]     rx_din, rx_dout;
    logic [CW-1:0]     rx_count;

    logic              start, lb_push, ser_start;
    logic              eng_busy, eng_done;
    logic [WW-1:0]     eng_rx;

    stat_t             stat;
    irq_t              raw;
    logic [3:0]        active;

    assign reg_sel = bus_addr[AW-1:2];
    assign id_win  = (bus_addr[AW-1:5] == '1);
    assign fmask   = frame_mask(frame_q[SIZE_W-1:0]);

    // Register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            ctrl_q  <= '0;
            div_q   <= '0;
            ien_q   <= '0;
        end else if (bus_wr && !id_win) begin
            case (reg_sel)
                RG_FRAME: frame_q <= bus_wdata;
                RG_CTRL:  ctrl_q  <= bus_wdata[3:0];
                RG_DIV:   div_q   <= bus_wdata[DIV_W-1:0];
                RG_IEN:   ien_q   <= bus_wdata[3:0];
                default:  ;
            endcase
        end
    end

    // Queue access from the bus
    assign tx_push = bus_wr && !id_win && (reg_sel == RG_DATA) && !tx_full;
    assign tx_din  = WW'(bus_wdata) & fmask;
    assign rx_pop  = bus_rd && !id_win && (reg_sel == RG_DATA) && !rx_empty;

    // Transfer sequencing: one word in flight, receive slot reserved by the
    // fact that only the sequencer pushes into the receive queue.
    assign start     = ctrl_q[CB_ENABLE] && !tx_empty && (rx_count < CW'(DEPTH)) && !eng_busy;
    assign tx_pop    = start;
    assign lb_push   = start && ctrl_q[CB_LOOP];
    assign ser_start = start && !ctrl_q[CB_LOOP];
    assign rx_push   = lb_push || eng_done;
    assign rx_din    = (lb_push ? tx_dout : eng_rx) & fmask;

    spim_fifo #(.W(WW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .push(tx_push), .din(tx_din), .pop(tx_pop),
        .dout(tx_dout), .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.W(WW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .din(rx_din), .pop(rx_pop),
        .dout(rx_dout), .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    spim_shifter #(.W(WW), .SW(SIZE_W), .DW(DIV_W)) u_shift (
        .clk(clk), .rst(rst), .start(ser_start), .word(tx_dout),
        .top_bit(frame_q[SIZE_W-1:0]), .div(div_q), .miso(spi_miso),
        .sclk(spi_sclk), .mosi(spi_mosi), .ncs(spi_ncs),
        .busy(eng_busy), .done(eng_done), .rx_word(eng_rx)
    );

    // Status and interrupts
    always_comb begin
        stat.tx_empty  = tx_empty;
        stat.tx_nfull  = !tx_full;
        stat.rx_nempty = !rx_empty;
        stat.rx_full   = rx_full;
        stat.busy      = !tx_empty;
        raw.unused     = 2'b00;
        raw.rx_high    = (rx_count >= CW'(HALF));
        raw.tx_low     = (tx_count <= CW'(HALF));
    end

    assign active = raw & ien_q;
    assign irq    = |active;

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (id_win) begin
            bus_rdata = {8'h00, id_byte(bus_addr[4:2])};
        end else begin
            case (reg_sel)
                RG_FRAME: bus_rdata = frame_q;
                RG_CTRL:  bus_rdata = {12'h000, ctrl_q};
                RG_DATA:  bus_rdata = rx_empty ? 16'h0000 : 16'(rx_dout);
                RG_STAT:  bus_rdata = {11'h000, stat};
                RG_DIV:   bus_rdata = 16'(div_q);
                RG_IEN:   bus_rdata = {12'h000, ien_q};
                RG_IRAW:  bus_rdata = {12'h000, raw};
                RG_IACT:  bus_rdata = {12'h000, active};
                default:  bus_rdata = '0;
            endcase
        end
    end

    assert_tx_hold_when_off_R5: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[CB_ENABLE] && !tx_push) |=> (tx_count == $past(tx_count)));

    assert_rx_room_R6: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> !rx_full);

    assert_loop_no_frame_R7: assert property (@(posedge clk) disable iff (rst)
        lb_push |=> spi_ncs);

    assert_irq_follows_mask_R10: assert property (@(posedge clk) disable iff (rst)
        (ien_q == '0) |-> !irq);

endmodule

// File: tb/spi_fifo_master_test.sv
`timescale 1ns/1ps
module spi_fifo_master_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] bus_addr;
    logic        bus_wr, bus_rd;
    logic [15:0] bus_wdata, bus_rdata;
    logic        irq, spi_sclk, spi_mosi, spi_miso, spi_ncs;

    int nchecks = 0;
    int nfails  = 0;

    always #4 clk = ~clk;

    assign spi_miso = ~spi_mosi;

    spi_fifo_master uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_ncs(spi_ncs)
    );

    // Serial-line monitor, sampled on the falling clock edge
    logic        prev_sclk = 1'b0;
    int          rise_cnt = 0;
    int          hi_cnt = 0;
    int          hi_len = 0;
    logic [15:0] mosi_word = '0;
    logic        ncs_seen = 1'b0;

    always @(negedge clk) begin
        if (spi_sclk && !prev_sclk) begin
            rise_cnt  = rise_cnt + 1;
            mosi_word = {mosi_word[14:0], spi_mosi};
        end
        if (spi_sclk) hi_cnt = hi_cnt + 1;
        else if (prev_sclk) begin
            hi_len = hi_cnt;
            hi_cnt = 0;
        end
        if (!spi_ncs) ncs_seen = 1'b1;
        prev_sclk = spi_sclk;
    end

    task automatic clear_mon();
        rise_cnt = 0; hi_cnt = 0; hi_len = 0; mosi_word = '0; ncs_seen = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchecks++;
        if (act !== exp) begin
            nfails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        clear_mon();
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // {size[3:0], written word, expected word after loopback}
    localparam logic [35:0] VEC [6] = '{
        {4'd7,  16'h1234, 16'h0034},
        {4'd3,  16'hABCD, 16'h000D},
        {4'd15, 16'hBEEF, 16'hBEEF},
        {4'd0,  16'h0003, 16'h0001},
        {4'd11, 16'hF5A5, 16'h05A5},
        {4'd4,  16'h00FF, 16'h001F}
    };

    localparam logic [7:0] IDV [8] = '{8'h22, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    initial begin
        repeat (150000) @(posedge clk);
        nfails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        do_reset();

        // R1 reset state
        rd(12'h00C, v); chk("R1 status", v, 16'h0003);
        rd(12'h018, v); chk("R1 raw", v, 16'h0008);
        rd(12'h014, v); chk("R1 mask", v, 16'h0000);
        rd(12'h01C, v); chk("R1 masked", v, 16'h0000);
        chk("R1 irq", {15'b0, irq}, 16'h0000);

        // R2 / R7 vector table, loopback
        wr(12'h004, 16'h0003);
        for (int i = 0; i < 6; i++) begin
            wr(12'h000, {12'h000, VEC[i][35:32]});
            wr(12'h008, VEC[i][31:16]);
            wait_cyc(3);
            rd(12'h008, v);
            chk($sformatf("R2 R7 vector %0d", i), v, VEC[i][15:0]);
        end
        chk("R7 ncs stayed high", {15'b0, ncs_seen}, 16'h0000);
        chk("R7 no sclk edges", 16'(rise_cnt), 16'h0000);

        // R4 empty read
        rd(12'h008, v); chk("R4 empty read", v, 16'h0000);
        rd(12'h00C, v); chk("R4 status unchanged", v, 16'h0003);

        // R3 / R5 overflow with port disabled
        do_reset();
        wr(12'h000, 16'h0007);
        for (int i = 0; i < 9; i++) wr(12'h008, 16'(8'h40 + i));
        wait_cyc(5);
        rd(12'h00C, v); chk("R5 R9 tx full, nothing sent", v, 16'h0010);
        rd(12'h018, v); chk("R10 raw tx full", v, 16'h0000);
        wr(12'h004, 16'h0003);
        wait_cyc(12);
        for (int i = 0; i < 8; i++) begin
            rd(12'h008, v); chk($sformatf("R3 order %0d", i), v, 16'(8'h40 + i));
        end
        rd(12'h008, v); chk("R3 ninth dropped", v, 16'h0000);
        rd(12'h00C, v); chk("R3 status empty", v, 16'h0003);

        // R6 / R9 / R10 receive full stalls transmit
        do_reset();
        wr(12'h000, 16'h0007);
        wr(12'h004, 16'h0003);
        for (int i = 0; i < 10; i++) wr(12'h008, 16'(8'h80 + i));
        wait_cyc(5);
        rd(12'h00C, v); chk("R6 R9 stalled status", v, 16'h001E);
        rd(12'h018, v); chk("R10 raw both", v, 16'h000C);
        wr(12'h014, 16'h0004);
        rd(12'h01C, v); chk("R10 masked", v, 16'h0004);
        chk("R10 irq high", {15'b0, irq}, 16'h0001);
        wr(12'h014, 16'h0001);
        chk("R10 irq low", {15'b0, irq}, 16'h0000);
        rd(12'h008, v); chk("R6 first", v, 16'h0080);
        wait_cyc(3);
        rd(12'h00C, v); chk("R6 one released", v, 16'h001E);
        for (int i = 1; i < 10; i++) begin
            rd(12'h008, v); chk($sformatf("R6 order %0d", i), v, 16'(8'h80 + i));
            wait_cyc(2);
        end
        rd(12'h00C, v); chk("R6 drained", v, 16'h0003);

        // R8 / R11 serial frame, miso returns inverted mosi
        do_reset();
        wr(12'h000, 16'h0007);
        wr(12'h010, 16'h01FF);
        rd(12'h010, v); chk("R11 prescale 8 bits", v, 16'h00FF);
        wr(12'h010, 16'h0002);
        wr(12'h004, 16'h0002);
        clear_mon();
        wr(12'h008, 16'h01A5);
        wait_cyc(100);
        chk("R8 rising edges", 16'(rise_cnt), 16'h0008);
        chk("R8 msb first", {8'h00, mosi_word[7:0]}, 16'h00A5);
        chk("R8 ncs asserted", {15'b0, ncs_seen}, 16'h0001);
        chk("R11 half period 2", 16'(hi_len), 16'h0002);
        rd(12'h008, v); chk("R8 received word", v, 16'h005A);
        chk("R8 ncs idle", {15'b0, spi_ncs}, 16'h0001);

        wr(12'h010, 16'h0000);
        wr(12'h000, 16'h0003);
        clear_mon();
        wr(12'h008, 16'h0009);
        wait_cyc(40);
        chk("R8 4-bit edges", 16'(rise_cnt), 16'h0004);
        chk("R11 half period floor", 16'(hi_len), 16'h0001);
        rd(12'h008, v); chk("R8 4-bit received", v, 16'h0006);

        // R12 identification window
        for (int i = 0; i < 8; i++) begin
            rd(12'hFE0 + 12'(4 * i), v);
            chk($sformatf("R12 id %0d", i), v, {8'h00, IDV[i]});
        end

        // R13 DMA and unmapped
        wr(12'h020, 16'hFFFF);
        rd(12'h020, v); chk("R13 dma reads 0", v, 16'h0000);
        wr(12'h030, 16'hFFFF);
        rd(12'h030, v); chk("R13 unmapped reads 0", v, 16'h0000);
        rd(12'h00C, v); chk("R13 state untouched", v, 16'h0003);
        rd(12'h000, v); chk("R13 frame untouched", v, 16'h0003);

        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
        $finish;
    end

endmodule